// File: doc/BRIEF.md
# Memory Port Sleep Sequencer

This controller sits between a host and one port of a synchronous dual-port memory and handles that port's low-power sleep. The host raises an asynchronous sleep request whenever it wants the port powered down. It also supplies a chip-enable request, a read/write flag and an address on every cycle. The sequencer drives the enable, write strobe, address and sleep line of the memory port. It also drives an output-enable gate and a read-data-valid marker.

Entering and leaving sleep are each wrapped in a window of deselected cycles. On the way in, the port stays awake but deselected for three cycles, then asleep and deselected for two more. On the way out, it stays asleep and deselected for one cycle, then awake and deselected for three more. Host accesses that fall inside these windows are blocked and recorded in a sticky violation flag. After wake-up, the first enabled access is forced to be a read. The memory's outputs are re-enabled only after two back-to-back enabled cycles.

Top module: `port_sleep_seq`

## Requirements
- R1: While rst_ni is low and on release, mem_ce_o, mem_we_o, mem_sleep_o, out_en_o, rdata_valid_o and viol_o are all 0, and the port is awake and idle.
- R2: sleep_req_i passes through two synchronizer flops. A level change of sleep_req_i starts an entry or exit sequence on the third rising edge after it is driven.
- R3: Entry window: after the sequence starts, the port stays awake with access blocked for 3 cycles. mem_sleep_o then rises and access stays blocked for 2 more cycles before the port is settled asleep.
- R4: While mem_sleep_o is 1, mem_ce_o, mem_we_o and out_en_o are 0. Host requests made while settled asleep are ignored and do not set viol_o.
- R5: Exit window: after sleep_req_i is seen low, mem_sleep_o stays 1 with access blocked for 1 cycle. mem_sleep_o then falls and access stays blocked for 3 more cycles before normal operation resumes.
- R6: The first enabled access after wake-up is issued as a read (mem_we_o = 0) even when a write is requested. Later writes drive mem_we_o = 1.
- R7: out_en_o is 1 only when mem_ce_o was 1 in both of the two previous cycles. A single cycle with mem_ce_o = 0 drops it.
- R8: rdata_valid_o is 1 when out_en_o is 1 and a read was issued to the memory in the previous cycle.
- R9: viol_o is set by a chip-enable request in any entry or exit window cycle, or by a write request on the first access after wake-up. It stays set until viol_clr_i is 1 at a clock edge. A set in the same cycle takes priority over the clear.
- R10: In normal operation mem_ce_o follows ce_req_i and mem_we_o is 1 when rd_nwr_i = 0 (write). When mem_ce_o is 0, mem_we_o is 0 and mem_addr_o is all zeros; otherwise mem_addr_o equals addr_i.
- R11: Once an entry sequence has started, it runs to the settled-asleep state even if sleep_req_i drops meanwhile. The exit sequence then follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Port clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_req_i | input | 1 | Asynchronous sleep request, active high |
| ce_req_i | input | 1 | Host access request |
| rd_nwr_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | ADDR_W | Host address |
| viol_clr_i | input | 1 | Clears the violation flag |
| mem_ce_o | output | 1 | Memory port enable |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | ADDR_W | Memory address, zero when not enabled |
| mem_sleep_o | output | 1 | Memory sleep line |
| out_en_o | output | 1 | Memory output-driver enable |
| rdata_valid_o | output | 1 | Read data on the memory port is valid |
| viol_o | output | 1 | Sticky access-violation flag |

## Verification
The assertions assume that rst_ni is released synchronously away from a clock edge. They also assume that sleep_req_i, ce_req_i, rd_nwr_i and viol_clr_i change only between edges. The bench drives every input right after a falling edge. When it needs to see the combinational blocking of mem_ce_o without starting a write or a violation, it raises ce_req_i briefly and drops it again before the next rising edge. The sleep request is held for many cycles at a time, so the synchronizer never has to resolve a pulse shorter than one cycle.

// File: rtl/pss_pkg.sv
package pss_pkg;
  typedef enum logic [2:0] {
    ST_NORMAL,
    ST_PRE_SLEEP,
    ST_SLEEP_HOLD,
    ST_SLEEP,
    ST_PRE_WAKE,
    ST_WAKE_HOLD
  } pss_state_e;
endpackage

// File: rtl/pss_sync.sv
module pss_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/pss_fsm.sv
module pss_fsm
  import pss_pkg::*;
#(
  parameter int PRE_SLEEP_CYC  = 3,
  parameter int POST_SLEEP_CYC = 2,
  parameter int PRE_WAKE_CYC   = 1,
  parameter int POST_WAKE_CYC  = 3,
  localparam int MAX_A = (PRE_SLEEP_CYC > POST_SLEEP_CYC) ? PRE_SLEEP_CYC : POST_SLEEP_CYC,
  localparam int MAX_B = (PRE_WAKE_CYC > POST_WAKE_CYC) ? PRE_WAKE_CYC : POST_WAKE_CYC,
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B,
  localparam int CNT_W = (MAX_C > 1) ? $clog2(MAX_C) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sleep_i,
  input  logic             acc_i,
  output pss_state_e       state_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wake_first_o
);
  localparam logic [CNT_W-1:0] LD_PRE_SLEEP  = CNT_W'(PRE_SLEEP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_POST_SLEEP = CNT_W'(POST_SLEEP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_PRE_WAKE   = CNT_W'(PRE_WAKE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_POST_WAKE  = CNT_W'(POST_WAKE_CYC - 1);

  pss_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wf_q, wf_d;
  logic             cnt_done;

  assign cnt_done = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_NORMAL: if (sleep_i) begin
        state_d = ST_PRE_SLEEP;
        cnt_d   = LD_PRE_SLEEP;
      end
      ST_PRE_SLEEP: if (cnt_done) begin
        state_d = ST_SLEEP_HOLD;
        cnt_d   = LD_POST_SLEEP;
      end else cnt_d = cnt_q - 1'b1;
      ST_SLEEP_HOLD: if (cnt_done) state_d = ST_SLEEP;
                     else cnt_d = cnt_q - 1'b1;
      ST_SLEEP: if (!sleep_i) begin
        state_d = ST_PRE_WAKE;
        cnt_d   = LD_PRE_WAKE;
      end
      ST_PRE_WAKE: if (cnt_done) begin
        state_d = ST_WAKE_HOLD;
        cnt_d   = LD_POST_WAKE;
      end else cnt_d = cnt_q - 1'b1;
      ST_WAKE_HOLD: if (cnt_done) state_d = ST_NORMAL;
                    else cnt_d = cnt_q - 1'b1;
      default: state_d = ST_NORMAL;
    endcase
  end

  // pending until the first enabled access after wake-up
  always_comb begin
    wf_d = wf_q;
    if (state_q == ST_WAKE_HOLD && cnt_done) wf_d = 1'b1;
    else if (acc_i)                          wf_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_NORMAL;
      cnt_q   <= '0;
      wf_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      wf_q    <= wf_d;
    end
  end

  assign state_o      = state_q;
  assign cnt_o        = cnt_q;
  assign wake_first_o = wf_q;
endmodule

// File: rtl/pss_gate.sv
module pss_gate
  import pss_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  pss_state_e        state_i,
  input  logic              wake_first_i,
  input  logic              ce_req_i,
  input  logic              rd_nwr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              viol_clr_i,
  output logic              mem_ce_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_sleep_o,
  output logic              out_en_o,
  output logic              rdata_valid_o,
  output logic              viol_o
);
  logic in_window, bad_req;
  logic ce_d1, ce_d2, rd_d1, viol_q;

  assign in_window = (state_i == ST_PRE_SLEEP) || (state_i == ST_SLEEP_HOLD) ||
                     (state_i == ST_PRE_WAKE)  || (state_i == ST_WAKE_HOLD);
  assign mem_sleep_o = (state_i == ST_SLEEP_HOLD) || (state_i == ST_SLEEP) ||
                       (state_i == ST_PRE_WAKE);

  assign mem_ce_o   = ce_req_i && (state_i == ST_NORMAL);
  assign mem_we_o   = mem_ce_o && !rd_nwr_i && !wake_first_i;
  assign mem_addr_o = mem_ce_o ? addr_i : '0;

  assign bad_req = ce_req_i && (in_window ||
                   (state_i == ST_NORMAL && wake_first_i && !rd_nwr_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_d1  <= 1'b0;
      ce_d2  <= 1'b0;
      rd_d1  <= 1'b0;
      viol_q <= 1'b0;
    end else begin
      ce_d1  <= mem_ce_o;
      ce_d2  <= ce_d1;
      rd_d1  <= mem_ce_o && !mem_we_o;
      if (bad_req)         viol_q <= 1'b1;
      else if (viol_clr_i) viol_q <= 1'b0;
    end
  end

  assign out_en_o      = ce_d1 && ce_d2;
  assign rdata_valid_o = out_en_o && rd_d1;
  assign viol_o        = viol_q;
endmodule

// File: rtl/port_sleep_seq.sv
module port_sleep_seq
  import pss_pkg::*;
#(
  parameter int ADDR_W         = 18,
  parameter int SYNC_STAGES    = 2,
  parameter int PRE_SLEEP_CYC  = 3,
  parameter int POST_SLEEP_CYC = 2,
  parameter int PRE_WAKE_CYC   = 1,
  parameter int POST_WAKE_CYC  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_req_i,
  input  logic              ce_req_i,
  input  logic              rd_nwr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              viol_clr_i,
  output logic              mem_ce_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_sleep_o,
  output logic              out_en_o,
  output logic              rdata_valid_o,
  output logic              viol_o
);
  localparam int MAX_A = (PRE_SLEEP_CYC > POST_SLEEP_CYC) ? PRE_SLEEP_CYC : POST_SLEEP_CYC;
  localparam int MAX_B = (PRE_WAKE_CYC > POST_WAKE_CYC) ? PRE_WAKE_CYC : POST_WAKE_CYC;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = (MAX_C > 1) ? $clog2(MAX_C) : 1;

  logic             sleep_s;
  pss_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wake_first;

  pss_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sleep_req_i),
    .q_o   (sleep_s)
  );

  pss_fsm #(
    .PRE_SLEEP_CYC (PRE_SLEEP_CYC),
    .POST_SLEEP_CYC(POST_SLEEP_CYC),
    .PRE_WAKE_CYC  (PRE_WAKE_CYC),
    .POST_WAKE_CYC (POST_WAKE_CYC)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sleep_i     (sleep_s),
    .acc_i       (mem_ce_o),
    .state_o     (state_q),
    .cnt_o       (cnt_q),
    .wake_first_o(wake_first)
  );

  pss_gate #(.ADDR_W(ADDR_W)) u_gate (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .state_i      (state_q),
    .wake_first_i (wake_first),
    .ce_req_i     (ce_req_i),
    .rd_nwr_i     (rd_nwr_i),
    .addr_i       (addr_i),
    .viol_clr_i   (viol_clr_i),
    .mem_ce_o     (mem_ce_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_sleep_o  (mem_sleep_o),
    .out_en_o     (out_en_o),
    .rdata_valid_o(rdata_valid_o),
    .viol_o       (viol_o)
  );
endmodule

// File: rtl/pss_checker.sv
module pss_checker
  import pss_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       viol_clr_i,
  input logic       mem_ce_o,
  input logic       mem_we_o,
  input logic       mem_sleep_o,
  input logic       out_en_o,
  input logic       viol_o,
  input pss_state_e state_i,
  input logic       wake_first_i
);
  a_r4_asleep_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_sleep_o |-> (!mem_ce_o && !mem_we_o && !out_en_o));

  a_r3_blocked_outside_normal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != ST_NORMAL) |-> !mem_ce_o);

  a_r3_sleep_rise_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_sleep_o) |-> (state_i == ST_SLEEP_HOLD && $past(state_i) == ST_PRE_SLEEP));

  a_r5_sleep_fall_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_sleep_o) |-> (state_i == ST_WAKE_HOLD && $past(state_i) == ST_PRE_WAKE));

  a_r6_wake_read_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_first_i && mem_ce_o) |-> !mem_we_o);

  a_r7_out_en_two_cycles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_en_o |-> ($past(mem_ce_o) && $past(mem_ce_o, 2)));

  a_r9_viol_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_o && !viol_clr_i) |=> viol_o);

  a_r10_we_needs_ce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_ce_o);
endmodule

bind port_sleep_seq pss_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .viol_clr_i  (viol_clr_i),
  .mem_ce_o    (mem_ce_o),
  .mem_we_o    (mem_we_o),
  .mem_sleep_o (mem_sleep_o),
  .out_en_o    (out_en_o),
  .viol_o      (viol_o),
  .state_i     (state_q),
  .wake_first_i(wake_first)
);

// File: tb/port_sleep_seq_test.sv
`timescale 1ns/1ps
module port_sleep_seq_test;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          sleep_req = 1'b0, ce_req = 1'b0, rd_nwr = 1'b1, viol_clr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          mem_ce, mem_we, mem_sleep, out_en, rdata_valid, viol;
  logic [AW-1:0] mem_addr;
  int            n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  port_sleep_seq #(.ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .sleep_req_i(sleep_req), .ce_req_i(ce_req),
    .rd_nwr_i(rd_nwr), .addr_i(addr), .viol_clr_i(viol_clr),
    .mem_ce_o(mem_ce), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_sleep_o(mem_sleep), .out_en_o(out_en), .rdata_valid_o(rdata_valid),
    .viol_o(viol)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  // probe blocking combinationally without letting an edge see the request
  task automatic probe_blocked(input string req);
    ce_req = 1'b1; rd_nwr = 1'b1; #1;
    chk(req, mem_ce, 0);
    ce_req = 1'b0; #0.5;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 ce in reset", mem_ce, 0);
    chk("R1 sleep in reset", mem_sleep, 0);
    chk("R1 oe in reset", out_en, 0);
    chk("R1 viol in reset", viol, 0);
    tick(2);
    rst_ni = 1'b1;
    tick();
    chk("R1 valid after reset", rdata_valid, 0);
    chk("R1 we after reset", mem_we, 0);
  endtask

  task automatic t_normal();
    ce_req = 1; rd_nwr = 0; addr = 18'h2A5A5; #1;
    chk("R10 ce follows req", mem_ce, 1);
    chk("R10 write strobe", mem_we, 1);
    chk("R10 addr passes", mem_addr, 18'h2A5A5);
    tick();
    rd_nwr = 1; #1;
    chk("R10 read no strobe", mem_we, 0);
    tick();
    chk("R7 oe after two enables", out_en, 1);
    chk("R8 valid after read", rdata_valid, 1);
    ce_req = 0; #1;
    chk("R10 addr zero idle", mem_addr, 0);
    chk("R10 we zero idle", mem_we, 0);
    tick();
    chk("R7 oe drops after one idle", out_en, 0);
    ce_req = 1; rd_nwr = 0;
    tick();
    chk("R7 oe off after one enable", out_en, 0);
    tick();
    chk("R7 oe back after two", out_en, 1);
    chk("R8 no valid after write", rdata_valid, 0);
    ce_req = 0; rd_nwr = 1;
    tick(2);
  endtask

  task automatic t_entry();
    sleep_req = 1;
    tick();
    chk("R2 awake after edge1", mem_sleep, 0);
    ce_req = 1; #1;
    chk("R2 access open after edge1", mem_ce, 1);
    ce_req = 0;
    tick();
    ce_req = 1; #1;
    chk("R2 access open after edge2", mem_ce, 1);
    ce_req = 0;
    tick();
    // pre-sleep window, set and clear together
    ce_req = 1; viol_clr = 1; #1;
    chk("R3 blocked pre-sleep", mem_ce, 0);
    chk("R3 awake pre-sleep", mem_sleep, 0);
    tick();
    chk("R9 set wins over clear", viol, 1);
    ce_req = 0;
    tick();
    chk("R9 cleared", viol, 0);
    viol_clr = 0;
    probe_blocked("R3 blocked last pre-sleep");
    chk("R3 still awake", mem_sleep, 0);
    tick();
    chk("R3 sleep rises", mem_sleep, 1);
    probe_blocked("R3 blocked sleep hold");
    tick(2);
    chk("R4 asleep", mem_sleep, 1);
    ce_req = 1; rd_nwr = 0;
    tick();
    chk("R4 no enable asleep", mem_ce, 0);
    chk("R4 no strobe asleep", mem_we, 0);
    chk("R4 no oe asleep", out_en, 0);
    chk("R4 asleep request ignored", viol, 0);
    ce_req = 0; rd_nwr = 1;
    tick(3);
  endtask

  task automatic t_exit();
    sleep_req = 0;
    tick(2);
    chk("R5 still asleep edge2", mem_sleep, 1);
    tick();
    chk("R5 pre-wake still asleep", mem_sleep, 1);
    ce_req = 1; #1;
    chk("R5 blocked pre-wake", mem_ce, 0);
    tick();
    chk("R9 viol from pre-wake", viol, 1);
    chk("R5 sleep falls", mem_sleep, 0);
    ce_req = 0; viol_clr = 1;
    tick();
    chk("R9 clear", viol, 0);
    viol_clr = 0;
    probe_blocked("R5 blocked wake hold");
    tick();
    probe_blocked("R5 blocked last wake hold");
    tick();
    ce_req = 1; rd_nwr = 0; addr = 18'h00033; #1;
    chk("R6 first access enabled", mem_ce, 1);
    chk("R6 first access forced read", mem_we, 0);
    tick();
    chk("R9 viol from wake write", viol, 1);
    #1;
    chk("R6 second write strobes", mem_we, 1);
    ce_req = 0; rd_nwr = 1; viol_clr = 1;
    tick();
    viol_clr = 0;
    chk("R9 clear after wake", viol, 0);
    tick(2);
  endtask

  task automatic t_commit();
    sleep_req = 1;
    tick(3);
    sleep_req = 0;
    tick(3);
    chk("R11 entry not aborted", mem_sleep, 1);
    tick(2);
    chk("R11 reaches sleep", mem_sleep, 1);
    tick();
    chk("R11 pre-wake follows", mem_sleep, 1);
    tick();
    chk("R11 wake hold follows", mem_sleep, 0);
    probe_blocked("R11 blocked wake hold");
    tick(3);
    ce_req = 1; rd_nwr = 1; #1;
    chk("R11 normal again", mem_ce, 1);
    ce_req = 0;
    chk("R11 no stray viol", viol, 0);
    tick(2);
  endtask

  initial begin
    t_reset();
    t_normal();
    t_entry();
    t_exit();
    t_commit();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule